// File: doc/BRIEF.md
# Second-Tick Phase Error Meter

This block measures the phase of a local oscillator against a once-per-second timing reference. An 8-bit counter runs without stopping on the oscillator clock and wraps round many times within each second. The counter is never cleared by the reference. When the reference rises, the block captures the wrapped low byte of the count. A correct oscillator therefore produces a capture value that is predictable from one second to the next. The block subtracts a per-second expected value from each capture and reports the signed difference as a phase error, together with a one-cycle valid pulse. A loop controller downstream uses this error to steer the oscillator.

The expected value starts at the counter midpoint, 128. After every capture it advances by a runtime step, modulo 256. A step of zero suits an oscillator frequency that is a whole multiple of 256 Hz. For any other whole-hertz frequency, the step is set to that frequency modulo 256.

A capture that reads all ones is taken to be a sample caught while the counter was changing. For that second the block reports zero error and raises a flag. The reference input is asynchronous, so the block brings it into the clock domain with a flop chain followed by an edge detector.

Top module: `ppm_phase_meter`

## Requirements
- R1: After reset the counter holds 0. It adds 1 on every clock edge and wraps from 255 to 0.
- R2: Suppose `pps_async` is low before clock edge k and high from before edge k up to edge k+2. Then the captured value is the counter value held between edges k+1 and k+2. The result for that capture appears after edge k+2.
- R3: Each rising edge of `pps_async` yields exactly one capture, however long the input then stays high.
- R4: `err_valid_o` is high for exactly one cycle per capture. `err_o` changes only on the edge that raises `err_valid_o` and holds its value until the next capture.
- R5: For a captured value other than 0xFF, `err_o` equals the captured value minus the expected value, modulo 256. Read as two's complement, it covers -128 to 127.
- R6: After reset the expected value is 128.
- R7: After each capture, the expected value advances by `step_in` modulo 256. `step_in` is sampled in the capture cycle. The advance also happens when the capture was 0xFF.
- R8: When `step_in` is 0 in the capture cycle, the expected value stays unchanged.
- R9: A captured value of 0xFF gives `err_o` = 0 and `glitch_o` = 1. `glitch_o` is high only in the cycle where `err_valid_o` is high for such a capture.
- R10: While reset is asserted, `err_o`, `err_valid_o` and `glitch_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock that also drives the counter |
| rst_n | input | 1 | Asynchronous reset, active low |
| pps_async | input | 1 | Once-per-second reference, asynchronous to `clk` |
| step_in | input | 8 | Per-second advance of the expected value |
| err_o | output | 8 | Phase error in two's complement |
| err_valid_o | output | 1 | One-cycle strobe marking a new error |
| glitch_o | output | 1 | Marks an error that was forced to zero because the capture read 0xFF |

## Verification
The assertions assume that `pps_async`, once it has risen, stays high for at least two clock cycles. They also assume it stays low for at least three cycles between rising edges, so that no edge falls inside the synchroniser window. They further assume that `step_in` is stable around each capture. The bench drives the reference on falling clock edges. It holds the reference high for three or more cycles and low for six or more. It changes `step_in` only while the reference is low and no capture is in flight. It places each rising edge so that the capture lands on a chosen counter value, including 0xFF, values on both sides of the midpoint, and values after a wrap.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
    localparam int COUNT_W = 8;
    localparam logic [COUNT_W-1:0] MIDPOINT  = 1 << (COUNT_W - 1);
    localparam logic [COUNT_W-1:0] ALL_ONES  = '1;
    localparam logic [COUNT_W-1:0] CNT_ONE   = 1;

    typedef logic [COUNT_W-1:0] count_t;

    typedef struct packed {
        count_t err;
        logic   valid;
        logic   glitch;
    } result_t;
endpackage

// File: rtl/ppm_pps_sync.sv
module ppm_pps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_async,
    output logic capture_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pps_async};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign capture_o = st_q.sync[STAGES-1] & ~st_q.prev;

    p_one_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |=> !capture_o);
endmodule

// File: rtl/ppm_wrap_counter.sv
module ppm_wrap_counter
    import ppm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output count_t count_o
);
    count_t count_d, count_q;

    always_comb begin
        count_d = count_q + CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = count_q;

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == ALL_ONES) |=> (count_q == '0));
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != ALL_ONES) |=> (count_q > $past(count_q)));
endmodule

// File: rtl/ppm_expect_track.sv
module ppm_expect_track
    import ppm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   capture_i,
    input  count_t step_i,
    output count_t expect_o
);
    count_t expect_d, expect_q;

    always_comb begin
        expect_d = expect_q;
        if (capture_i) expect_d = expect_q + step_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) expect_q <= MIDPOINT;
        else        expect_q <= expect_d;
    end

    assign expect_o = expect_q;

    p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(expect_q));
    p_zero_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && step_i == '0) |=> $stable(expect_q));
endmodule

// File: rtl/ppm_phase_meter.sv
module ppm_phase_meter
    import ppm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pps_async,
    input  logic [7:0] step_in,
    output logic [7:0] err_o,
    output logic       err_valid_o,
    output logic       glitch_o
);
    logic   capture;
    count_t count;
    count_t expected;

    ppm_pps_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pps_async (pps_async),
        .capture_o (capture)
    );

    ppm_wrap_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (count)
    );

    ppm_expect_track u_exp (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .step_i    (step_in),
        .expect_o  (expected)
    );

    result_t res_d, res_q;

    always_comb begin
        res_d        = res_q;
        res_d.valid  = 1'b0;
        res_d.glitch = 1'b0;
        if (capture) begin
            res_d.valid = 1'b1;
            if (count == ALL_ONES) begin
                res_d.err    = '0;
                res_d.glitch = 1'b1;
            end else begin
                res_d.err    = count - expected;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign err_o       = res_q.err;
    assign err_valid_o = res_q.valid;
    assign glitch_o    = res_q.glitch;

    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid_o |=> !err_valid_o);
    p_err_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid_o |-> $stable(err_o));
    p_glitch_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        glitch_o |-> (err_valid_o && err_o == '0));
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |-> (!err_valid_o && !glitch_o && err_o == '0));
endmodule

// File: tb/ppm_phase_meter_tb.sv
module ppm_phase_meter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pps_async = 1'b0;
    logic [7:0] step_in = 8'd0;
    logic [7:0] err_o;
    logic       err_valid_o;
    logic       glitch_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_cnt;
    logic [7:0] m_exp = 8'd128;
    logic [8:0] q_exp[$];
    logic [7:0] last_err = 8'd0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ppm_phase_meter u_dut (
        .clk(clk), .rst_n(rst_n), .pps_async(pps_async), .step_in(step_in),
        .err_o(err_o), .err_valid_o(err_valid_o), .glitch_o(glitch_o)
    );

    // Independent model of the free-running count (R1)
    always @(posedge clk or negedge rst_n)
        if (!rst_n) m_cnt <= 8'd0;
        else        m_cnt <= m_cnt + 8'd1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: place a rising edge so the capture lands on target (R2)
    task automatic pulse(input logic [7:0] target, input logic [7:0] step, input int hold);
        step_in = step;
        forever begin
            @(negedge clk);
            if (m_cnt + 8'd2 == target) break;
        end
        pps_async = 1'b1;
        if (target == 8'hFF) q_exp.push_back({1'b1, 8'h00});
        else                 q_exp.push_back({1'b0, target - m_exp});
        m_exp = m_exp + step;
        repeat (hold) @(negedge clk);
        pps_async = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // Monitor: pops one expected item per valid, checks hold otherwise
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (err_valid_o) begin
                if (q_exp.size() == 0) begin
                    check(1'b0, "R3 extra result", 1, 0);
                end else begin
                    logic [8:0] e;
                    e = q_exp.pop_front();
                    check(err_o == e[7:0], "R5/R2 error value", err_o, e[7:0]);
                    check(glitch_o == e[8], "R9 glitch flag", glitch_o, e[8]);
                end
                last_err = err_o;
            end else begin
                check(err_o == last_err, "R4 error hold", err_o, last_err);
                check(glitch_o == 1'b0, "R9 glitch without valid", glitch_o, 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: quiet outputs in reset
        check(err_o == 8'd0, "R10 err in reset", err_o, 0);
        check(err_valid_o == 1'b0, "R10 valid in reset", err_valid_o, 0);
        check(glitch_o == 1'b0, "R10 glitch in reset", glitch_o, 0);
        rst_n = 1'b1;
        // R6/R8: expected fixed at 128 with step 0
        pulse(8'd200, 8'd0, 3);   // 72
        pulse(8'd128, 8'd0, 3);   // 0
        pulse(8'd0,   8'd0, 3);   // -128, after a wrap (R1)
        pulse(8'd127, 8'd0, 3);   // -1
        pulse(8'hFF,  8'd0, 3);   // R9 glitch
        pulse(8'd129, 8'd0, 40);  // R3: long high level, single result, +1
        // R7: advancing expected value
        pulse(8'd10,  8'd64, 3);  // -118, expected -> 192
        pulse(8'd192, 8'd64, 3);  // 0, expected -> 0
        pulse(8'd5,   8'd64, 3);  // 5, expected -> 64
        pulse(8'hFF,  8'd64, 3);  // R9 glitch, R7 still advances -> 128
        pulse(8'd130, 8'd0, 3);   // 2
        pulse(8'd50,  8'd200, 4); // -78, expected -> 72
        pulse(8'd70,  8'd0, 3);   // -2
        repeat (4) @(negedge clk);
        done = 1'b1;
        check(q_exp.size() == 0, "R4 missing results", q_exp.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule